// File: doc/BRIEF.md
# Latched Status Register Bank

This block holds one 16-bit bank of sticky event flags plus a companion interrupt-enable register. Each flag captures a rising edge on its own event input, and a flag chosen for change tracking also captures a falling edge. Once set, a flag stays set until the host clears it. The host picks one of two clearing styles with a configuration input. In clear-by-read mode, reading the flag register empties the part that was read. In clear-by-write mode, each 1 written to a bit position clears that bit.

The host bus runs either 16 bits wide or 8 bits wide. In narrow mode one address bit picks the byte lane, and data always travels on the low byte. A single interrupt line is high while any flag is set and enabled. Address decoding for the wider register map lives outside this block, and so do the event sources. The data-path reset puts every register back to zero.

Top module: `evt_latch_bank`

## Requirements
- R1: A 0-to-1 change on `evtIn[i]` sets flag i at the clock edge that samples the change. The flag stays set until it is cleared.
- R2: An event held high neither sets its flag again after a clear nor sets it when it is already high as the data-path reset is released. Only a fresh rising edge sets the flag.
- R3: Bits selected in the `CHANGE_MASK` parameter (default 16'h0F00) also set on a 1-to-0 change. Other bits ignore falling edges.
- R4: With `clrOnWrite`=0 and `wide16`=1, a read of the flag register (`busAddr[1]`=0) returns the flag value from before the read on `busRdata` one clock later and clears all 16 flags.
- R5: With `wide16`=0, `busAddr[0]` picks the lane (0 = bits 7:0, 1 = bits 15:8). Read data appears on `busRdata[7:0]` with `busRdata[15:8]`=0, and a clearing read clears only the selected lane.
- R6: With `clrOnWrite`=1, writing the flag register clears each flag whose data bit is 1, and a 0 leaves the flag alone. Reads do not clear. In 8-bit mode `busWdata[7:0]` applies to the selected lane only.
- R7: With `clrOnWrite`=0, writes to the flag register have no effect.
- R8: If a new edge arrives on the same clock as a clear of that bit, the flag ends up set.
- R9: The enable register (`busAddr[1]`=1) can be read and written, with byte-lane writes in 8-bit mode. Neither clear style touches it.
- R10: `irq` is high exactly when some flag is set and its enable bit is 1. It follows the registers with no extra delay.
- R11: Bits that are 0 in `USED_MASK` (default 16'hBFFF, so bit 14 is unused) never set, ignore enable writes and read as 0.
- R12: While `dpRstN` is low, all flags, enable bits and the read-data register go to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| dpRstN | input | 1 | Data-path reset, active low |
| evtIn | input | 16 | Event levels, one per flag |
| wide16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| clrOnWrite | input | 1 | 1 = clear by writing ones, 0 = clear by reading |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busAddr | input | 2 | Bit 1 selects the register (0 flags, 1 enables); bit 0 selects the lane in 8-bit mode |
| busWdata | input | 16 | Write data; low byte only in 8-bit mode |
| busRdata | output | 16 | Registered read data |
| irq | output | 1 | OR of the enabled flags |

## Verification
An event change driven before a clock edge shows up in the flags, and therefore in `irq`, right after that edge. Read data and any clearing caused by a read both take effect at the edge that samples the read strobe. The bench drives every input at the falling edge. A driver task queues each expected read value. A monitor waits for the rising edge that sees the strobe and then compares `busRdata` at the next falling edge. Checks on `irq` are taken at a falling edge once the stimulus edge has passed, so each value is sampled one clock edge after its cause.

// File: rtl/evt_latch_pkg.sv
package evt_latch_pkg;
  parameter int unsigned LAT_W = 16;
  parameter int unsigned LANE_W = 8;
  localparam int unsigned NUM_LANES = LAT_W / LANE_W;
  localparam int unsigned LANE_IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int unsigned ADDR_W = LANE_IDX_W + 1;

  // Strobes passed from the bus control to the datapath each cycle
  typedef struct packed {
    logic [LAT_W-1:0]      clrMask;
    logic [LAT_W-1:0]      enWrMask;
    logic [LAT_W-1:0]      enWrData;
    logic                  rdEn;
    logic                  rdEnReg;
    logic                  rdNarrow;
    logic [LANE_IDX_W-1:0] rdLane;
  } latStrobe_t;
endpackage

// File: rtl/evt_latch_ctrl.sv
module evt_latch_ctrl
  import evt_latch_pkg::*;
(
  input  logic              clk,
  input  logic              dpRstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LAT_W-1:0]  busWdata,
  input  logic              wide16,
  input  logic              clrOnWrite,
  output latStrobe_t        strb
);
  logic [LAT_W-1:0]      laneMask;
  logic [LAT_W-1:0]      laneData;
  logic                  regSel;
  logic [LANE_IDX_W-1:0] laneIdx;

  assign regSel  = busAddr[ADDR_W-1];
  assign laneIdx = busAddr[LANE_IDX_W-1:0];

  // One slice per byte lane: pick the lane and steer the write byte to it
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign laneMask[l*LANE_W +: LANE_W] =
      (wide16 || laneIdx == LANE_IDX_W'(l)) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
    assign laneData[l*LANE_W +: LANE_W] =
      wide16 ? busWdata[l*LANE_W +: LANE_W] : busWdata[LANE_W-1:0];
  end

  always_comb begin
    strb = '0;
    if (busRd && !regSel && !clrOnWrite)
      strb.clrMask = laneMask;
    if (busWr && !regSel && clrOnWrite)
      strb.clrMask = strb.clrMask | (laneData & laneMask);
    if (busWr && regSel)
      strb.enWrMask = laneMask;
    strb.enWrData = laneData;
    strb.rdEn     = busRd;
    strb.rdEnReg  = regSel;
    strb.rdNarrow = !wide16;
    strb.rdLane   = laneIdx;
  end

  AST_NARROW_ONE_LANE: assert property (@(posedge clk) disable iff (!dpRstN)
    !wide16 |-> ($countones(strb.clrMask) <= LANE_W)); // R5
  AST_COR_WRITE_INERT: assert property (@(posedge clk) disable iff (!dpRstN)
    (!clrOnWrite && !busRd) |-> (strb.clrMask == '0)); // R7
endmodule

// File: rtl/evt_latch_dp.sv
module evt_latch_dp
  import evt_latch_pkg::*;
#(
  parameter logic [LAT_W-1:0] USED_MASK   = 16'hBFFF,
  parameter logic [LAT_W-1:0] CHANGE_MASK = 16'h0F00
)(
  input  logic             clk,
  input  logic             dpRstN,
  input  logic [LAT_W-1:0] evtIn,
  input  latStrobe_t       strb,
  output logic [LAT_W-1:0] rdData,
  output logic             irq
);
  logic [LAT_W-1:0] evtPrev;
  logic [LAT_W-1:0] latched;
  logic [LAT_W-1:0] enableReg;
  logic [LAT_W-1:0] setVec;
  logic [LAT_W-1:0] rdSrc;
  logic [LAT_W-1:0] rdView;

  // Rising edges on every bit, falling edges only where change tracking is on
  assign setVec = ((evtIn & ~evtPrev) | (~evtIn & evtPrev & CHANGE_MASK)) & USED_MASK;

  always_comb begin
    rdSrc = strb.rdEnReg ? enableReg : latched;
    if (strb.rdNarrow)
      rdView = LAT_W'(rdSrc[int'(strb.rdLane)*LANE_W +: LANE_W]);
    else
      rdView = rdSrc;
  end

  always_ff @(posedge clk) begin
    if (!dpRstN) begin
      evtPrev   <= evtIn;
      latched   <= '0;
      enableReg <= '0;
      rdData    <= '0;
    end else begin
      evtPrev   <= evtIn;
      latched   <= ((latched & ~strb.clrMask) | setVec) & USED_MASK;
      enableReg <= ((enableReg & ~strb.enWrMask) | (strb.enWrData & strb.enWrMask)) & USED_MASK;
      if (strb.rdEn)
        rdData <= rdView;
    end
  end

  assign irq = |(latched & enableReg);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!dpRstN)
    (setVec != '0) |=> ((latched & $past(setVec)) == $past(setVec))); // R8
  AST_CLEAR_ONLY_ASKED: assert property (@(posedge clk) disable iff (!dpRstN)
    (latched != '0) |=> ((($past(latched) & ~latched) & ~$past(strb.clrMask)) == '0)); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!dpRstN)
    ((latched | enableReg) & ~USED_MASK) == '0); // R11
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !dpRstN |=> (latched == '0 && enableReg == '0)); // R12
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank
  import evt_latch_pkg::*;
#(
  parameter logic [LAT_W-1:0] USED_MASK   = 16'hBFFF,
  parameter logic [LAT_W-1:0] CHANGE_MASK = 16'h0F00
)(
  input  logic              clk,
  input  logic              dpRstN,
  input  logic [LAT_W-1:0]  evtIn,
  input  logic              wide16,
  input  logic              clrOnWrite,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LAT_W-1:0]  busWdata,
  output logic [LAT_W-1:0]  busRdata,
  output logic              irq
);
  latStrobe_t strb;

  evt_latch_ctrl u_ctrl (
    .clk(clk), .dpRstN(dpRstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .wide16(wide16),
    .clrOnWrite(clrOnWrite), .strb(strb)
  );

  evt_latch_dp #(.USED_MASK(USED_MASK), .CHANGE_MASK(CHANGE_MASK)) u_dp (
    .clk(clk), .dpRstN(dpRstN), .evtIn(evtIn), .strb(strb),
    .rdData(busRdata), .irq(irq)
  );
endmodule

// File: tb/tb_evt_latch_bank.sv
module tb_evt_latch_bank;
  logic        clk = 1'b0;
  logic        dpRstN = 1'b0;
  logic [15:0] evtIn = '0;
  logic        wide16 = 1'b1;
  logic        clrOnWrite = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq;

  int nChk = 0;
  int nFail = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  evt_latch_bank dut (
    .clk(clk), .dpRstN(dpRstN), .evtIn(evtIn), .wide16(wide16),
    .clrOnWrite(clrOnWrite), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: after a rising edge that saw a read strobe, compare at the falling edge
  initial forever begin
    @(posedge clk);
    if (busRd) begin
      @(negedge clk);
      if (expQ.size() > 0) chk(busRdata, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic doRead(input logic [1:0] a, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic setEvt(input logic [15:0] v);
    evtIn = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    evtIn = 16'h0001;                 // level held through reset (R2)
    repeat (3) @(negedge clk);
    dpRstN = 1'b1;
    @(negedge clk);
    chk({15'd0, irq}, 16'h0000, "R12 irq after reset");
    doRead(2'b00, 16'h0000, "R12/R2 flags after reset");
    doRead(2'b10, 16'h0000, "R12 enables after reset");
    doWrite(2'b10, 16'hFFFF);
    doRead(2'b10, 16'hBFFF, "R11 unused enable bit");
    setEvt(16'h0003);
    chk({15'd0, irq}, 16'h0001, "R10 irq on enabled flag");
    doRead(2'b00, 16'h0002, "R1 rise sets flag");
    doRead(2'b00, 16'h0000, "R4 read clears all");
    @(negedge clk); @(negedge clk);
    doRead(2'b00, 16'h0000, "R2 steady level no reset");
    setEvt(16'h0103);
    doRead(2'b00, 16'h0100, "R3 rise on change bit");
    setEvt(16'h4002);
    doRead(2'b00, 16'h0100, "R3 fall only on change bit, R11 bit14");
    setEvt(16'h4406);
    wide16 = 1'b0;
    doRead(2'b00, 16'h0004, "R5 low lane read");
    doRead(2'b00, 16'h0000, "R5 low lane cleared");
    doRead(2'b01, 16'h0004, "R5 high lane untouched by low read");
    doRead(2'b01, 16'h0000, "R5 high lane cleared");
    setEvt(16'h4407);
    wide16 = 1'b1;
    doWrite(2'b00, 16'hFFFF);
    doRead(2'b00, 16'h0001, "R7 write ignored in read-clear mode");
    clrOnWrite = 1'b1;
    setEvt(16'h0000);
    setEvt(16'h00F0);
    doRead(2'b00, 16'h04F0, "R6 read does not clear");
    doRead(2'b00, 16'h04F0, "R6 read does not clear again");
    doWrite(2'b00, 16'h0010);
    doRead(2'b00, 16'h04E0, "R6 write one clears bit");
    wide16 = 1'b0;
    doWrite(2'b01, 16'h0004);
    wide16 = 1'b1;
    doRead(2'b00, 16'h00E0, "R6 narrow high-lane write");
    wide16 = 1'b0;
    doWrite(2'b00, 16'h00A0);
    wide16 = 1'b1;
    doRead(2'b00, 16'h0040, "R6 narrow low-lane write");
    doWrite(2'b00, 16'hFFFF);
    doRead(2'b00, 16'h0000, "R6 write all ones");
    // R8: edge and clear on the same clock
    evtIn = 16'h00F8;
    doWrite(2'b00, 16'h0008);
    doRead(2'b00, 16'h0008, "R8 set beats clear");
    doRead(2'b10, 16'hBFFF, "R9 enables untouched by clears");
    wide16 = 1'b0;
    doWrite(2'b11, 16'h0000);
    wide16 = 1'b1;
    doRead(2'b10, 16'h00FF, "R9 narrow enable write");
    chk({15'd0, irq}, 16'h0001, "R10 irq with bit3 enabled");
    doWrite(2'b10, 16'h0000);
    chk({15'd0, irq}, 16'h0000, "R10 irq masked");
    doRead(2'b00, 16'h0008, "R9 enable write keeps flags");
    doWrite(2'b10, 16'hFFFF);
    chk({15'd0, irq}, 16'h0001, "R10 irq re-enabled");
    dpRstN = 1'b0;
    @(negedge clk);
    dpRstN = 1'b1;
    chk({15'd0, irq}, 16'h0000, "R12 irq after data-path reset");
    chk(busRdata, 16'h0000, "R12 read data cleared");
    doRead(2'b00, 16'h0000, "R12 flags cleared");
    doRead(2'b10, 16'h0000, "R12 enables cleared");
    @(negedge clk);
    summary();
  end
endmodule